// File: doc/BRIEF.md
# Page Erase Command Sequencer

This block takes a command of three 16-bit words from a valid/ready input stream and treats it as a request to erase a run of flash pages. The first word holds an operation code, a length code and a page count. The second and third words together give a 24-bit start address. The block checks that the command is well formed and that the start address sits on a page boundary. If both checks pass, it walks through the pages one at a time. For each page it raises a request to a flash controller and waits for that controller's completion pulse before it moves the address on by one page.

When the walk is finished, or when the command is refused, the block sends a two-word status response on a valid/ready output stream. The input stream is held off from the moment the third command word is accepted until the second response word has been taken. So exactly one command is in flight at any time.

Top module: `pgerase_seq`

## Requirements
- R1: Word 0 is decoded as operation code in bits 15:12 (must be 0x9), length code in bits 11:8 (must be 0x3) and page count in bits 7:0 (1 to 255).
- R2: The start address is formed as {word1[7:0], word2[15:0]}, and the first erase request carries exactly this address.
- R3: A valid command produces exactly as many erase requests as its page count. Each request's address is the previous one plus 0x400, modulo 2^24.
- R4: Only one erase request is outstanding at a time. erase_req stays high with erase_addr stable until erase_done is seen, and then drops for at least one cycle before the next request.
- R5: After the last page of a valid command, the response is 0x1900 followed by 0x0002.
- R6: A command is refused if the operation code is not 0x9, the length code is not 0x3, the page count is zero, or address bits 9:0 are not zero. A refused command raises no erase request and answers {4'h2, received operation code, 8'h00} followed by 0x0002.
- R7: in_ready is low while a command is being checked, erased or answered. Input words offered in that time are not taken.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R9: After reset, in_ready is 1, out_valid is 0 and erase_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Block accepts a command word |
| in_data | input | 16 | Command word |
| erase_req | output | 1 | Page erase request to the flash controller |
| erase_addr | output | 24 | Address of the page being erased |
| erase_done | input | 1 | One-cycle completion pulse from the flash controller |
| out_valid | output | 1 | Response word offered |
| out_ready | input | 1 | Consumer takes the response word |
| out_data | output | 16 | Response word |

## Verification
The page loop is driven with a single page at address zero and with three pages at a mid-range address, which separates a correct count from an off-by-one. A run of two pages starting just below a 64K boundary shows whether the carry reaches the high address byte. A full run of 255 pages exercises the counter limit. Four refused commands each break exactly one condition: a wrong operation code, a wrong length code, a misaligned address and a zero page count. This tells each rejection path apart and confirms the echoed operation code. A response held under backpressure, and input words offered while the block is busy, test the two stream boundaries.

// File: rtl/pgerase_pkg.sv
package pgerase_pkg;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 24;
  localparam int CNT_W      = 8;
  localparam int PAGE_SHIFT = 10;
  localparam logic [ADDR_W-1:0] PAGE_SPAN = ADDR_W'(1) << PAGE_SHIFT;

  localparam logic [3:0]        OP_ERASE  = 4'h9;
  localparam logic [3:0]        LEN_ERASE = 4'h3;
  localparam logic [WORD_W-1:0] RESP_OK   = 16'h1900;
  localparam logic [WORD_W-1:0] RESP_LEN  = 16'h0002;
  localparam logic [3:0]        FAIL_NIB  = 4'h2;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_CHECK,
    ST_ERASE,
    ST_RESP
  } seq_state_t;

  function automatic logic [3:0] op_of(input logic [WORD_W-1:0] w);
    return w[15:12];
  endfunction

  function automatic logic [3:0] len_of(input logic [WORD_W-1:0] w);
    return w[11:8];
  endfunction

  function automatic logic [CNT_W-1:0] pages_of(input logic [WORD_W-1:0] w);
    return w[CNT_W-1:0];
  endfunction

  function automatic logic page_aligned(input logic [ADDR_W-1:0] a);
    return a[PAGE_SHIFT-1:0] == '0;
  endfunction

  function automatic logic cmd_ok(input logic [WORD_W-1:0] w0,
                                  input logic [ADDR_W-1:0] a);
    return (op_of(w0) == OP_ERASE) && (len_of(w0) == LEN_ERASE) &&
           (pages_of(w0) != '0) && page_aligned(a);
  endfunction

  function automatic logic [WORD_W-1:0] fail_code(input logic [3:0] op);
    return {FAIL_NIB, op, 8'h00};
  endfunction

  function automatic logic [ADDR_W-1:0] next_page(input logic [ADDR_W-1:0] a);
    return a + PAGE_SPAN;
  endfunction
endpackage

// File: rtl/pgerase_cmd_rx.sv
module pgerase_cmd_rx
  import pgerase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              cmd_full,
  output logic [WORD_W-1:0] head_q,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int HI_W = ADDR_W - WORD_W;

  logic [1:0] widx_q;
  logic       fire;

  assign fire     = accept_en && in_valid;
  assign cmd_full = fire && (widx_q == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      widx_q <= 2'd0;
      head_q <= '0;
      addr_q <= '0;
    end else if (fire) begin
      unique case (widx_q)
        2'd0: head_q <= in_data;
        2'd1: addr_q[ADDR_W-1:WORD_W] <= in_data[HI_W-1:0];
        default: addr_q[WORD_W-1:0] <= in_data;
      endcase
      widx_q <= (widx_q == 2'd2) ? 2'd0 : widx_q + 2'd1;
    end
  end
endmodule

// File: rtl/pgerase_walker.sv
module pgerase_walker
  import pgerase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  page_cnt,
  input  logic              erase_done,
  output logic              erase_req,
  output logic [ADDR_W-1:0] erase_addr,
  output logic              step_evt,
  output logic              walk_fin
);
  typedef enum logic [1:0] {W_IDLE, W_REQ, W_GAP} walk_t;

  walk_t            ph_q;
  logic [CNT_W-1:0] left_q;
  logic             last_page;

  assign erase_req = (ph_q == W_REQ);
  assign last_page = (left_q == CNT_W'(1));
  assign step_evt  = erase_req && erase_done && !last_page;
  assign walk_fin  = erase_req && erase_done && last_page;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q       <= W_IDLE;
      left_q     <= '0;
      erase_addr <= '0;
    end else begin
      unique case (ph_q)
        W_IDLE: if (start) begin
          ph_q       <= W_REQ;
          left_q     <= page_cnt;
          erase_addr <= start_addr;
        end
        W_REQ: if (erase_done) begin
          if (last_page) begin
            ph_q <= W_IDLE;
          end else begin
            ph_q       <= W_GAP;
            left_q     <= left_q - CNT_W'(1);
            erase_addr <= next_page(erase_addr);
          end
        end
        default: ph_q <= W_REQ;
      endcase
    end
  end
endmodule

// File: rtl/pgerase_resp_tx.sv
module pgerase_resp_tx
  import pgerase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] code,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              resp_done
);
  logic              idx_q;
  logic [WORD_W-1:0] code_q;

  assign out_data  = idx_q ? RESP_LEN : code_q;
  assign resp_done = out_valid && out_ready && idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      idx_q     <= 1'b0;
      code_q    <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      idx_q     <= 1'b0;
      code_q    <= code;
    end else if (out_valid && out_ready) begin
      if (idx_q) begin
        out_valid <= 1'b0;
        idx_q     <= 1'b0;
      end else begin
        idx_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pgerase_seq.sv
module pgerase_seq
  import pgerase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              erase_req,
  output logic [ADDR_W-1:0] erase_addr,
  input  logic              erase_done,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  seq_state_t        state_q, state_d;
  logic              cmd_full;
  logic [WORD_W-1:0] head_q;
  logic [ADDR_W-1:0] addr_q;
  logic              good_cmd;
  logic              accept_evt;
  logic              reject_evt;
  logic              step_evt;
  logic              walk_fin;
  logic              resp_load;
  logic [WORD_W-1:0] resp_code;
  logic              resp_done;

  assign in_ready   = (state_q == ST_COLLECT);
  assign good_cmd   = cmd_ok(head_q, addr_q);
  assign accept_evt = (state_q == ST_CHECK) && good_cmd;
  assign reject_evt = (state_q == ST_CHECK) && !good_cmd;
  assign resp_load  = reject_evt || walk_fin;
  assign resp_code  = reject_evt ? fail_code(op_of(head_q)) : RESP_OK;

  pgerase_cmd_rx u_rx (
    .clk(clk), .rst_n(rst_n), .accept_en(in_ready), .in_valid(in_valid),
    .in_data(in_data), .cmd_full(cmd_full), .head_q(head_q), .addr_q(addr_q)
  );

  pgerase_walker u_walk (
    .clk(clk), .rst_n(rst_n), .start(accept_evt), .start_addr(addr_q),
    .page_cnt(pages_of(head_q)), .erase_done(erase_done),
    .erase_req(erase_req), .erase_addr(erase_addr),
    .step_evt(step_evt), .walk_fin(walk_fin)
  );

  pgerase_resp_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(resp_load), .code(resp_code),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .resp_done(resp_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COLLECT: if (cmd_full) state_d = ST_CHECK;
      ST_CHECK:   state_d = good_cmd ? ST_ERASE : ST_RESP;
      ST_ERASE:   if (walk_fin) state_d = ST_RESP;
      default:    if (resp_done) state_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_COLLECT;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pgerase_seq_chk.sv
module pgerase_seq_chk
  import pgerase_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              erase_req,
  input logic [ADDR_W-1:0] erase_addr,
  input logic              erase_done,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              step_evt,
  input logic              reject_evt
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && !erase_done |=> erase_req && $stable(erase_addr));

  // R4
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && erase_done |=> !erase_req);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> erase_addr == $past(erase_addr) + PAGE_SPAN);

  // R6
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> !erase_req && out_valid);

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req || out_valid) |-> !in_ready);

  // R8
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind pgerase_seq pgerase_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .erase_req(erase_req),
  .erase_addr(erase_addr), .erase_done(erase_done), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .step_evt(step_evt),
  .reject_evt(reject_evt)
);

// File: tb/pgerase_seq_bench.sv
module pgerase_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        erase_req;
  logic [23:0] erase_addr;
  logic        erase_done = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  int n_erase = 0;
  logic [23:0] log_q [0:255];
  bit finished = 0;

  always #2 clk = ~clk;

  pgerase_seq u_pgerase_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .erase_req(erase_req), .erase_addr(erase_addr),
    .erase_done(erase_done), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // flash controller model: done pulse two cycles into each request
  initial begin
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      if (erase_req && !erase_done) begin
        lat++;
        if (lat == 2) begin
          if (n_erase < 256) log_q[n_erase] = erase_addr;
          n_erase++;
          erase_done = 1'b1;
          lat = 0;
        end
      end else begin
        erase_done = 1'b0;
      end
    end
  end

  task automatic send_word(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // waits for a response word, holding out_ready low for 'hold' cycles
  task automatic take_word(input int hold, output logic [15:0] w, output int busy_bad);
    logic [15:0] first;
    busy_bad = 0;
    out_ready = 1'b0;
    while (!out_valid) begin
      if ((erase_req || erase_done) && in_ready) busy_bad++;
      @(negedge clk);
    end
    first = out_data;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R8 valid held", {31'd0, out_valid}, 32'd1);
      check("R8 data held", {16'd0, out_data}, {16'd0, first});
    end
    if (in_ready) busy_bad++;
    w = out_data;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_cmd(input string tag, input logic [15:0] w0, input logic [15:0] w1,
                         input logic [15:0] w2, input int exp_n, input logic [15:0] exp_r0,
                         input int hold);
    logic [15:0] r0, r1;
    logic [23:0] a;
    int bad0, bad1;
    n_erase = 0;
    send_word(w0);
    send_word(w1);
    send_word(w2);
    take_word(hold, r0, bad0);
    take_word(0, r1, bad1);
    check({tag, " R3 page count"}, n_erase, exp_n);
    a = {w1[7:0], w2};
    for (int i = 0; i < exp_n && i < 256; i++) begin
      if (i == 0) check({tag, " R2 first addr"}, {8'd0, log_q[i]}, {8'd0, a});
      else        check({tag, " R3 step addr"}, {8'd0, log_q[i]}, {8'd0, a});
      a = a + 24'h000400;
    end
    check({tag, " R5/R6 resp word0"}, {16'd0, r0}, {16'd0, exp_r0});
    check({tag, " R5/R6 resp word1"}, {16'd0, r1}, 32'h0002);
    check({tag, " R7 busy in_ready"}, bad0 + bad1, 0);
    @(negedge clk);
    check({tag, " R7 ready after"}, {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 in_ready", {31'd0, in_ready}, 32'd1);
    check("R9 out_valid", {31'd0, out_valid}, 32'd0);
    check("R9 erase_req", {31'd0, erase_req}, 32'd0);
  endtask

  task automatic t_busy_input();
    int taken_words;
    logic [15:0] r0, r1;
    int b0, b1;
    n_erase = 0;
    send_word(16'h9302);
    send_word(16'h0001);
    send_word(16'h0000);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'h9301;
    taken_words = 0;
    while (!out_valid) begin
      if (in_ready) taken_words++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check("R7 no word taken while busy", taken_words, 0);
    take_word(0, r0, b0);
    take_word(0, r1, b1);
    check("R7 busy cmd pages", n_erase, 2);
    run_cmd("R7 next cmd", 16'h9301, 16'h0000, 16'h0800, 1, 16'h1900, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_cmd("R1 single", 16'h9301, 16'h0000, 16'h0000, 1, 16'h1900, 0);
    run_cmd("R2 three", 16'h9303, 16'h0001, 16'h2800, 3, 16'h1900, 0);
    run_cmd("R3 carry", 16'h9302, 16'h0000, 16'hFC00, 2, 16'h1900, 0);
    run_cmd("R3 max", 16'h93FF, 16'h0000, 16'h0000, 255, 16'h1900, 0);
    run_cmd("R6 bad op", 16'h5303, 16'h0000, 16'h0000, 0, 16'h2500, 0);
    run_cmd("R6 bad len", 16'h9203, 16'h0000, 16'h0000, 0, 16'h2900, 0);
    run_cmd("R6 misalign", 16'h9302, 16'h0000, 16'h0200, 0, 16'h2900, 0);
    run_cmd("R6 zero pages", 16'h9300, 16'h0000, 16'h0000, 0, 16'h2900, 0);
    run_cmd("R8 backpressure", 16'h9302, 16'h0012, 16'h3400, 2, 16'h1900, 4);
    t_busy_input();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule